// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

After the core's internal reset is released, this block runs the power-up vector load. It waits a fixed start-up delay. It then makes four word reads on a 16-bit bus, one after the other. The first two reads build the 32-bit supervisor stack pointer and the next two build the 32-bit program counter. When the last word arrives, the block presents both values and an interrupt mask forced to its highest level, all at once. In that same cycle it raises a one-cycle strobe that lets the core begin its first instruction fetch at the loaded program counter.

Each read holds its address and read strobe until the bus answers with an acknowledge. The bus may take any number of cycles to answer. Asserting reset at any point abandons the sequence, and it restarts from the first read once reset is released again. Once the sequence is done, the block leaves the bus idle until the next reset.

Top module: `reset_vector_fetch`

## Requirements
- R1: While rstN is low, and on the first cycle after reset, busRd, loadStb and fetchGo are 0, and sspOut, pcOut and ipmOut are all 0.
- R2: busRd first goes high exactly START_DELAY rising clock edges after rstN goes high. The default START_DELAY is 4.
- R3: The four reads use byte addresses 0x00000, 0x00002, 0x00004 and 0x00006, in that order, and each read is issued once.
- R4: A read keeps busRd high and busAddr unchanged until it sees a rising edge with busAck high. Only then does the sequence move on.
- R5: sspOut equals {word at 0x00000, word at 0x00002}. The lower address holds the upper half.
- R6: pcOut equals {word at 0x00004, word at 0x00006}. The lower address holds the upper half.
- R7: ipmOut equals 7 from the cycle in which fetchGo is high.
- R8: fetchGo and loadStb are high together for exactly one cycle. This is the cycle after the acknowledged read of 0x00006. After it, busRd stays low until the next reset.
- R9: sspOut, pcOut and ipmOut change only in the cycle in which fetchGo is high. Partial results never appear on them.
- R10: Asserting rstN low during the sequence drops busRd and clears the outputs at once. After release, the sequence restarts from address 0x00000 after the full start-up delay.
- R11: busAck high while no read is pending has no effect. It does not shorten the delay, start a read or change any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | output | ADDR_W (20) | Byte address of the current vector read |
| busRd | output | 1 | Read request, held until acknowledged |
| busData | input | 16 | Read data, valid with busAck |
| busAck | input | 1 | Read acknowledge |
| sspOut | output | 32 | Loaded supervisor stack pointer |
| pcOut | output | 32 | Loaded program counter |
| ipmOut | output | 3 | Interrupt priority mask |
| loadStb | output | 1 | One-cycle strobe: output values were just loaded |
| fetchGo | output | 1 | One-cycle strobe: first instruction fetch may begin |

## Verification
Each run fills the four vector words with fresh random values, so that a swapped half or a swapped pointer shows up as a mismatch. The bus answers each read after a random latency of zero to three cycles. A zero-latency answer shows whether a read advances on the very first acknowledge. A longer latency shows whether the block holds the read and waits.

Directed runs cover three cases:
- A reset pulse that lands in the middle of the reads, which separates a true restart from a resume.
- Acknowledges driven while no read is pending, which must be ignored.
- Stale values left on the data bus, which must not be taken.

The edge on which the first read appears is counted against the start-up delay. Any later reads that appear after completion are caught.

// File: rtl/rvf_pkg.sv
package rvf_pkg;
  typedef struct packed {
    logic capSspHi;
    logic capSspLo;
    logic capPcHi;
    logic commit;
  } rvfStrobe_t;

  typedef enum logic [2:0] {
    ST_DELAY,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_RD3,
    ST_GO,
    ST_RUN
  } rvfState_t;
endpackage

// File: rtl/rvf_ctrl.sv
module rvf_ctrl
  import rvf_pkg::*;
#(
  parameter int START_DELAY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAck,
  output logic       busRd,
  output logic [1:0] wordIdx,
  output rvfStrobe_t strb,
  output logic       fetchGo
);
  localparam int CNT_W = (START_DELAY < 2) ? 1 : $clog2(START_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(START_DELAY - 1);

  rvfState_t state, stateNxt;
  logic [CNT_W-1:0] dlyCnt;
  logic reading;

  always_comb begin
    reading = (state == ST_RD0) || (state == ST_RD1) ||
              (state == ST_RD2) || (state == ST_RD3);
    stateNxt = state;
    case (state)
      ST_DELAY: if (dlyCnt == CNT_LAST) stateNxt = ST_RD0;
      ST_RD0:   if (busAck) stateNxt = ST_RD1;
      ST_RD1:   if (busAck) stateNxt = ST_RD2;
      ST_RD2:   if (busAck) stateNxt = ST_RD3;
      ST_RD3:   if (busAck) stateNxt = ST_GO;
      ST_GO:    stateNxt = ST_RUN;
      default:  stateNxt = state;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_DELAY;
      dlyCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_DELAY && dlyCnt != CNT_LAST) dlyCnt <= dlyCnt + 1'b1;
    end
  end

  always_comb begin
    busRd   = reading;
    fetchGo = (state == ST_GO);
    case (state)
      ST_RD1:  wordIdx = 2'd1;
      ST_RD2:  wordIdx = 2'd2;
      ST_RD3:  wordIdx = 2'd3;
      default: wordIdx = 2'd0;
    endcase
    strb.capSspHi = (state == ST_RD0) && busAck;
    strb.capSspLo = (state == ST_RD1) && busAck;
    strb.capPcHi  = (state == ST_RD2) && busAck;
    strb.commit   = (state == ST_RD3) && busAck;
  end
endmodule

// File: rtl/rvf_datapath.sv
module rvf_datapath
  import rvf_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int MASK_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  rvfStrobe_t          strb,
  input  logic [1:0]          wordIdx,
  input  logic [DATA_W-1:0]   busData,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [2*DATA_W-1:0] sspOut,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [MASK_W-1:0]   ipmOut,
  output logic                loadStb
);
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam logic [MASK_W-1:0] MASK_MAX = '1;

  logic [DATA_W-1:0] sspHi, sspLo, pcHi;

  assign busAddr = ADDR_W'(wordIdx) * ADDR_W'(BYTES_PER_WORD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sspHi   <= '0;
      sspLo   <= '0;
      pcHi    <= '0;
      sspOut  <= '0;
      pcOut   <= '0;
      ipmOut  <= '0;
      loadStb <= 1'b0;
    end else begin
      if (strb.capSspHi) sspHi <= busData;
      if (strb.capSspLo) sspLo <= busData;
      if (strb.capPcHi)  pcHi  <= busData;
      loadStb <= strb.commit;
      if (strb.commit) begin
        sspOut <= {sspHi, sspLo};
        pcOut  <= {pcHi, busData};
        ipmOut <= MASK_MAX;
      end
    end
  end
endmodule

// File: rtl/reset_vector_fetch.sv
module reset_vector_fetch
  import rvf_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int MASK_W      = 3,
  parameter int START_DELAY = 4
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busRd,
  input  logic [DATA_W-1:0]   busData,
  input  logic                busAck,
  output logic [2*DATA_W-1:0] sspOut,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [MASK_W-1:0]   ipmOut,
  output logic                loadStb,
  output logic                fetchGo
);
  rvfStrobe_t strb;
  logic [1:0] wordIdx;

  rvf_ctrl #(.START_DELAY(START_DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAck(busAck), .busRd(busRd),
    .wordIdx(wordIdx), .strb(strb), .fetchGo(fetchGo)
  );

  rvf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIdx(wordIdx),
    .busData(busData), .busAddr(busAddr), .sspOut(sspOut),
    .pcOut(pcOut), .ipmOut(ipmOut), .loadStb(loadStb)
  );
endmodule

// File: rtl/rvf_checker.sv
module rvf_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int MASK_W = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busRd,
  input logic                busAck,
  input logic [2*DATA_W-1:0] sspOut,
  input logic [2*DATA_W-1:0] pcOut,
  input logic [MASK_W-1:0]   ipmOut,
  input logic                loadStb,
  input logic                fetchGo
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(6);

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busAck) |=> (busRd && $stable(busAddr))); // R4
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRd) |-> (busAddr == '0)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAck && busAddr != LAST_ADDR) |=>
      (busRd && busAddr == $past(busAddr) + ADDR_W'(2))); // R3
  AST_LAST_TO_GO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAck && busAddr == LAST_ADDR) |=> (fetchGo && loadStb && !busRd)); // R8
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fetchGo |=> (!fetchGo && !loadStb && !busRd)); // R8
  AST_GO_MASK: assert property (@(posedge clk) disable iff (!rstN)
    fetchGo |-> (ipmOut == '1)); // R7
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !fetchGo |-> ($stable(sspOut) && $stable(pcOut) && $stable(ipmOut))); // R9
endmodule

bind reset_vector_fetch rvf_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)
) u_rvf_checker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busAck(busAck),
  .sspOut(sspOut), .pcOut(pcOut), .ipmOut(ipmOut), .loadStb(loadStb),
  .fetchGo(fetchGo)
);

// File: tb/reset_vector_fetch_tb.sv
module reset_vector_fetch_tb;
  localparam int ADDR_W = 20;
  localparam int START_DELAY = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr;
  logic busRd;
  logic [15:0] busData = '0;
  logic busAck = 1'b0;
  logic [31:0] sspOut, pcOut;
  logic [2:0] ipmOut;
  logic loadStb, fetchGo;

  int compared = 0;
  int mismatched = 0;

  logic [15:0] memW [4];
  logic [ADDR_W-1:0] addrLog [8];
  int logIdx = 0;
  int maxLat = 3;
  bit spurious = 1'b0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  reset_vector_fetch #(.START_DELAY(START_DELAY)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busData(busData), .busAck(busAck), .sspOut(sspOut), .pcOut(pcOut),
    .ipmOut(ipmOut), .loadStb(loadStb), .fetchGo(fetchGo)
  );

  function automatic logic [31:0] joinWords(logic [15:0] hi, logic [15:0] lo);
    return {hi, lo};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bus responder: random latency; logs each acknowledged address
  int waitCnt = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0;
      logIdx <= 0;
      waitCnt <= $urandom_range(maxLat, 0);
    end else if (!busRd) begin
      busAck <= spurious;
      busData <= 16'hDEAD;
    end else if (busAck) begin
      busAck <= 1'b0;
      busData <= 16'hBEEF;
      waitCnt <= $urandom_range(maxLat, 0);
    end else if (waitCnt > 0) begin
      waitCnt <= waitCnt - 1;
    end else begin
      busAck <= 1'b1;
      busData <= memW[busAddr[2:1]];
      if (logIdx < 8) addrLog[logIdx] <= busAddr;
      logIdx <= logIdx + 1;
    end
  end

  task automatic finishReport();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishReport();
    end
  end

  // Releases reset, checks delay, order, values and the single pulse
  task automatic runSequence(string tag);
    int cyc;
    bit seenGo;
    for (int i = 0; i < 4; i++) memW[i] = 16'($urandom);
    @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    while (cyc < 50) begin
      @(negedge clk);
      cyc++;
      if (busRd) break;
    end
    check({tag, " R2 start delay"}, 32'(cyc), 32'(START_DELAY));
    if (spurious) check({tag, " R11 no output change"}, pcOut, 32'h0);
    seenGo = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (fetchGo) begin seenGo = 1'b1; break; end
      if (sspOut !== 32'h0 || pcOut !== 32'h0 || ipmOut !== 3'd0)
        check({tag, " R9 early output"}, pcOut, 32'h0);
      @(negedge clk);
    end
    check({tag, " R8 fetchGo seen"}, 32'(seenGo), 32'd1);
    check({tag, " R8 loadStb with fetchGo"}, 32'(loadStb), 32'd1);
    check({tag, " R5 ssp"}, sspOut, joinWords(memW[0], memW[1]));
    check({tag, " R6 pc"}, pcOut, joinWords(memW[2], memW[3]));
    check({tag, " R7 mask"}, 32'(ipmOut), 32'd7);
    check({tag, " R3 read count"}, 32'(logIdx), 32'd4);
    for (int i = 0; i < 4; i++)
      check({tag, " R3 address order"}, 32'(addrLog[i]), 32'(2 * i));
    @(negedge clk);
    check({tag, " R8 pulse width"}, {30'b0, fetchGo, loadStb}, 32'd0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (busRd) check({tag, " R8 bus idle after"}, 32'(busRd), 32'd0);
    end
    check({tag, " R9 ssp held"}, sspOut, joinWords(memW[0], memW[1]));
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1ns;
    check("R1 reset busRd", 32'(busRd), 32'd0);
    check("R1 reset strobes", {30'b0, fetchGo, loadStb}, 32'd0);
    check("R1 reset outputs", sspOut | pcOut | 32'(ipmOut), 32'd0);
    repeat (3) @(negedge clk);

    // Zero-latency bus
    maxLat = 0;
    runSequence("lat0");

    // Random-latency runs
    maxLat = 3;
    for (int r = 0; r < 6; r++) begin
      @(negedge clk); rstN = 1'b0;
      repeat ($urandom_range(3, 1)) @(negedge clk);
      runSequence("rand");
    end

    // Abort mid-sequence (R10)
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) memW[i] = 16'($urandom);
    rstN = 1'b1;
    while (logIdx < 2) @(negedge clk);
    rstN = 1'b0;
    #1ns;
    check("R10 busRd dropped", 32'(busRd), 32'd0);
    check("R10 outputs cleared", sspOut | pcOut, 32'd0);
    repeat (2) @(negedge clk);
    runSequence("R10 restart");

    // Spurious acknowledges while idle (R11)
    @(negedge clk); rstN = 1'b0;
    spurious = 1'b1;
    repeat (2) @(negedge clk);
    runSequence("R11 spurious");
    spurious = 1'b0;

    done = 1'b1;
    finishReport();
  end
endmodule